// File: doc/BRIEF.md
# Store-Draining Write Buffer with Read-Miss Search

This block holds word stores that a write-through cache sends toward the next memory level. Each store is queued in a small first-in first-out structure. The cache keeps running while the stores drain in the background, and it stalls a store only when every slot is occupied. The memory side takes one entry at a time through a valid/ready handshake, always the oldest entry first. Because every store passes through the queue, memory ends up holding the same data as the cache.

A read miss can search the queue by word address before it goes out to memory. If any queued entry matches, the block returns that entry's data in the same cycle. When several queued entries carry the same address, the data written most recently is returned. The search covers the entries held in the queue at the start of the cycle. An entry stays visible to the search until the cycle in which memory accepts it.

Top module: `wbuf_top`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `mem_valid` = 0, `st_full` = 0 and `lk_hit` = 0 for every lookup address.
- R2: When `st_full` = 0, a store offered with `st_valid` = 1 is accepted at that clock edge. If the queue was empty, `mem_valid` = 1 in the next cycle, with `mem_addr`/`mem_data` equal to the stored word.
- R3: After DEPTH (default 4) accepted stores with no drain, `st_full` = 1. A store offered while `st_full` = 1 is dropped and never appears on the memory side.
- R4: Entries leave on the memory side in the order they were accepted. One entry leaves on each edge where `mem_valid` and `mem_ready` are both 1.
- R5: While `mem_valid` = 1 and `mem_ready` = 0, the next cycle keeps `mem_valid` = 1 with `mem_addr` and `mem_data` unchanged.
- R6: A lookup whose address equals the address of a queued entry gives `lk_hit` = 1 and that entry's data on `lk_data` in the same cycle. A lookup with no matching entry gives `lk_hit` = 0.
- R7: When more than one queued entry matches the lookup address, `lk_data` carries the data of the most recently accepted one.
- R8: When a store is accepted on the same edge that an entry drains, the occupancy does not change and `st_full` is computed from the updated count. From 3 entries such a cycle leaves `st_full` = 0, and exactly one further store then sets it.
- R9: An entry that has drained is no longer found by a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store offered by the cache |
| st_addr | input | 30 | Word address of the store |
| st_data | input | 32 | Store data |
| st_full | output | 1 | Queue full; the offered store is not taken |
| mem_valid | output | 1 | Oldest entry presented to memory |
| mem_ready | input | 1 | Memory accepts the presented entry |
| mem_addr | output | 30 | Word address of the oldest entry |
| mem_data | output | 32 | Data of the oldest entry |
| lk_addr | input | 30 | Word address searched by a read miss |
| lk_hit | output | 1 | A queued entry matches `lk_addr` |
| lk_data | output | 32 | Data of the youngest matching entry |

## Verification
The bench stores the same address three times with different data. A search that stops at the oldest or the first slot match would return stale data, not the youngest value. It offers a store while the queue is full and then drains everything. A design that overwrites a slot or lets the write pointer run ahead would emit the rejected word or lose an older one. It also stores and drains on the same edge with three entries held. A count that handles only one of the two updates would raise `st_full` one store early, or let a fifth entry overwrite live data. Lookups after a drain catch a search that ignores occupancy and still hits on stale slots.

// File: rtl/wbuf_pkg.sv
// Package: shared defaults and helpers for the store-draining write buffer.
// Assumes: depths are at least 1; widths are word address and word data.
package wbuf_pkg;
    parameter int unsigned WB_DEPTH = 4;
    parameter int unsigned WB_AW    = 30;
    parameter int unsigned WB_DW    = 32;

    // Number of bits needed to index a queue of the given depth (min 1).
    function automatic int unsigned idx_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Number of bits needed to hold an occupancy from 0 to depth.
    function automatic int unsigned cnt_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction
endpackage

// File: rtl/wbuf_ctrl.sv
// Module: wbuf_ctrl
// Keeps the write and read pointers and the occupancy count of the queue,
// and registers the full flag from the count after this cycle's push/pop.
// Assumes: push is never asserted while full, pop never while empty
// (the top module gates both).
module wbuf_ctrl #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned PW    = 2,
    parameter int unsigned CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] occ,
    output logic          full,
    output logic          empty
);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] occ_q, occ_d;
    logic          full_q;

    // Next occupancy: a push and a pop in the same cycle cancel out.
    always_comb begin
        occ_d = occ_q;
        if (push && !pop)
            occ_d = occ_q + CW'(1);
        else if (pop && !push)
            occ_d = occ_q - CW'(1);
    end

    // Write pointer advances on every accepted store, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_q <= '0;
        else if (push)
            wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + PW'(1);
    end

    // Read pointer advances on every drained entry, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (pop)
            rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + PW'(1);
    end

    // Occupancy and full flag, the flag taken from the updated count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= '0;
            full_q <= 1'b0;
        end else begin
            occ_q  <= occ_d;
            full_q <= (occ_d == FULL_CNT);
        end
    end

    assign wr_ptr = wr_q;
    assign rd_ptr = rd_q;
    assign occ    = occ_q;
    assign full   = full_q;
    assign empty  = (occ_q == '0);
endmodule

// File: rtl/wbuf_store.sv
// Module: wbuf_store
// Register file of queued entries: one write port at the write pointer,
// and every slot's address and data visible in parallel for the drain
// read and the associative search.
// Assumes: slot contents are meaningful only where the controller counts
// them as occupied; storage is not reset.
module wbuf_store #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned PW    = 2,
    parameter int unsigned AW    = 30,
    parameter int unsigned DW    = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] wsel,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] slot_addr [DEPTH],
    output logic [DW-1:0] slot_data [DEPTH]
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [AW-1:0] a_q;
        logic [DW-1:0] d_q;

        // Capture the store into this slot when it is the write target.
        always_ff @(posedge clk) begin
            if (we && (wsel == PW'(s))) begin
                a_q <= waddr;
                d_q <= wdata;
            end
        end

        assign slot_addr[s] = a_q;
        assign slot_data[s] = d_q;
    end
endmodule

// File: rtl/wbuf_search.sv
// Module: wbuf_search
// Associative lookup over occupied slots. It walks the slots from the
// youngest (one behind the write pointer) to the oldest, so the most
// recently accepted matching entry supplies the data.
// Assumes: occ never exceeds DEPTH.
module wbuf_search #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned PW    = 2,
    parameter int unsigned CW    = 3,
    parameter int unsigned AW    = 30,
    parameter int unsigned DW    = 32
) (
    input  logic [AW-1:0] slot_addr [DEPTH],
    input  logic [DW-1:0] slot_data [DEPTH],
    input  logic [PW-1:0] wr_ptr,
    input  logic [CW-1:0] occ,
    input  logic [AW-1:0] key,
    output logic          hit,
    output logic [DW-1:0] data
);
    logic [DEPTH-1:0] age_match;   // bit k: entry of age k (0 = youngest) matches
    logic [PW-1:0]    age_slot [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        // Slot index holding the entry of age k.
        assign age_slot[k] = PW'((int'(wr_ptr) + 2 * DEPTH - 1 - k) % DEPTH);
        // Match only when that age lies inside the current occupancy.
        assign age_match[k] = (CW'(k) < occ) && (slot_addr[age_slot[k]] == key);
    end

    // Priority select: the youngest matching age wins.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (age_match[k]) begin
                hit  = 1'b1;
                data = slot_data[age_slot[k]];
            end
        end
    end
endmodule

// File: rtl/wbuf_top.sv
// Module: wbuf_top
// Write buffer between a write-through cache and the next memory level.
// Stores enter when not full; the oldest entry is offered to memory with
// a valid/ready handshake; a read miss may search the queue by address.
// Assumes: the cache holds st_valid/st_addr/st_data while st_full is set
// if it still wants the store taken; lookups see the queue state at the
// start of the cycle (a same-cycle store is not searched).
module wbuf_top #(
    parameter int unsigned DEPTH = wbuf_pkg::WB_DEPTH,
    parameter int unsigned AW    = wbuf_pkg::WB_AW,
    parameter int unsigned DW    = wbuf_pkg::WB_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_full,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data
);
    localparam int unsigned PW = wbuf_pkg::idx_bits(DEPTH);
    localparam int unsigned CW = wbuf_pkg::cnt_bits(DEPTH);

    logic          push, pop, full, empty;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ;
    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];

    // Handshake qualification at both edges of the queue.
    assign push = st_valid && !full;
    assign pop  = !empty && mem_ready;

    wbuf_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop    (pop),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .occ    (occ),
        .full   (full),
        .empty  (empty)
    );

    wbuf_store #(.DEPTH(DEPTH), .PW(PW), .AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .we        (push),
        .wsel      (wr_ptr),
        .waddr     (st_addr),
        .wdata     (st_data),
        .slot_addr (slot_addr),
        .slot_data (slot_data)
    );

    wbuf_search #(.DEPTH(DEPTH), .PW(PW), .CW(CW), .AW(AW), .DW(DW)) u_search (
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .wr_ptr    (wr_ptr),
        .occ       (occ),
        .key       (lk_addr),
        .hit       (lk_hit),
        .data      (lk_data)
    );

    // Memory side presents the oldest slot while anything is queued.
    assign st_full   = full;
    assign mem_valid = !empty;
    assign mem_addr  = slot_addr[rd_ptr];
    assign mem_data  = slot_data[rd_ptr];
endmodule

// File: rtl/wbuf_checker.sv
// Module: wbuf_checker
// Temporal properties of the write buffer, bound onto wbuf_top.
// Assumes: occupancy is observed through the top's internal count.
module wbuf_checker #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = 30,
    parameter int unsigned DW    = 32,
    parameter int unsigned CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_full,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic          lk_hit,
    input logic [CW-1:0] occ
);
    // R1: the cycle after reset is asserted, nothing is pending or full.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_valid && !st_full));

    // R2: an accepted store makes an entry available to memory.
    assert_accept_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_full) |=> mem_valid);

    // R3: occupancy never goes beyond the depth.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R3: a full queue that does not drain stays full.
    assert_full_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && !(mem_valid && mem_ready)) |=> st_full);

    // R5: a stalled offer keeps its contents.
    assert_hold_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R6: an empty queue cannot produce a hit.
    assert_empty_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> !lk_hit);

    // R8: a simultaneous accept and drain leaves occupancy unchanged.
    assert_swap_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_full && mem_valid && mem_ready) |=> $stable(occ));
endmodule

bind wbuf_top wbuf_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_full   (st_full),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .lk_hit    (lk_hit),
    .occ       (occ)
);

// File: tb/sim_wbuf_top.sv
`timescale 1ns/1ps
// Directed bench for wbuf_top: inputs change on the falling edge, outputs
// are sampled on the falling edge, one task per scenario.
module sim_wbuf_top;
    localparam int AW = 30;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_full;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit;
    logic [DW-1:0] lk_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wbuf_top u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_full(st_full),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data)
    );

    // Compare one observed value with its expected value.
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one store for a single cycle; returns after the edge.
    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    // Check the offered head, then accept it for one cycle.
    task automatic drain_expect(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
        check(req, 64'(mem_valid), 64'd1);
        check(req, 64'(mem_addr), 64'(a));
        check(req, 64'(mem_data), 64'(d));
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    // Lookup (combinational) and compare hit and, on hit, data.
    task automatic lookup(input string req, input logic [AW-1:0] a, input logic h, input logic [DW-1:0] d);
        lk_addr = a;
        #0.5;
        check(req, 64'(lk_hit), 64'(h));
        if (h) check(req, 64'(lk_data), 64'(d));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mem_valid", 64'(mem_valid), 64'd0);
        check("R1 st_full", 64'(st_full), 64'd0);
        lookup("R1 lookup", 30'h0, 1'b0, '0);
    endtask

    task automatic t_single;
        store(30'h123, 32'hCAFE_0001);
        check("R2 mem_valid", 64'(mem_valid), 64'd1);
        lookup("R6 hit", 30'h123, 1'b1, 32'hCAFE_0001);
        lookup("R6 miss", 30'h124, 1'b0, '0);
        drain_expect("R2 head", 30'h123, 32'hCAFE_0001);
        check("R9 empty", 64'(mem_valid), 64'd0);
        lookup("R9 gone", 30'h123, 1'b0, '0);
    endtask

    task automatic t_fill_order;
        for (int i = 0; i < 4; i++) store(30'(16'h200 + i), 32'(32'hA000_0000 + i));
        check("R3 full", 64'(st_full), 64'd1);
        store(30'h3FF, 32'hDEAD_BEEF);          // rejected while full
        check("R3 still full", 64'(st_full), 64'd1);
        lookup("R3 dropped not found", 30'h3FF, 1'b0, '0);
        // R5: hold two cycles without ready, head must stay put
        @(negedge clk);
        check("R5 valid", 64'(mem_valid), 64'd1);
        check("R5 addr", 64'(mem_addr), 64'h200);
        @(negedge clk);
        check("R5 data", 64'(mem_data), 64'hA000_0000);
        for (int i = 0; i < 4; i++) drain_expect("R4 order", 30'(16'h200 + i), 32'(32'hA000_0000 + i));
        check("R3 no extra entry", 64'(mem_valid), 64'd0);
        check("R3 full clear", 64'(st_full), 64'd0);
    endtask

    task automatic t_youngest;
        store(30'h5, 32'h1111_1111);
        store(30'h6, 32'h2222_2222);
        store(30'h5, 32'h3333_3333);
        lookup("R7 youngest", 30'h5, 1'b1, 32'h3333_3333);
        lookup("R6 other", 30'h6, 1'b1, 32'h2222_2222);
        drain_expect("R4 first", 30'h5, 32'h1111_1111);
        lookup("R7 after drain", 30'h5, 1'b1, 32'h3333_3333);
        drain_expect("R4 second", 30'h6, 32'h2222_2222);
        lookup("R9 drained addr", 30'h6, 1'b0, '0);
        drain_expect("R4 third", 30'h5, 32'h3333_3333);
        lookup("R9 all drained", 30'h5, 1'b0, '0);
    endtask

    task automatic t_simul;
        for (int i = 0; i < 3; i++) store(30'(16'h40 + i), 32'(32'hB000_0000 + i));
        check("R8 not full at 3", 64'(st_full), 64'd0);
        // store and drain on the same edge
        st_valid = 1'b1; st_addr = 30'h43; st_data = 32'hB000_0003;
        mem_ready = 1'b1;
        @(negedge clk);
        st_valid = 1'b0; mem_ready = 1'b0;
        check("R8 full after swap", 64'(st_full), 64'd0);
        check("R8 head advanced", 64'(mem_addr), 64'h41);
        store(30'h44, 32'hB000_0004);
        check("R8 full after one more", 64'(st_full), 64'd1);
        for (int i = 1; i < 5; i++) drain_expect("R8 order", 30'(16'h40 + i), 32'(32'hB000_0000 + i));
        check("R8 empty", 64'(mem_valid), 64'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_fill_order();
        t_youngest();
        t_simul();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule